// File: doc/BRIEF.md
# Saturating Double-to-Integer Converter

This block turns a 64-bit IEEE-754 double into a signed two's-complement integer of 32 or 64 bits, picked by a parameter. Rounding follows a 2-bit mode input. A separate truncate control overrides the mode and always rounds toward zero. Values that cannot be represented, and every NaN, are clamped to a fixed limit. In those cases the block raises an invalid-conversion pulse, plus a second pulse when the NaN was a signalling one.

The block has a single register stage. An operand accepted with `in_valid` produces its result, status bits and exception pulses on the next cycle, under `out_valid`. A write-enable tells the register file whether to store the result. The write is withheld when the invalid-operation trap enable is set and the conversion was invalid. Two status bits come with every in-range result: one marks an inexact result, the other marks a result that was rounded away from zero.

Top module: `dbl2int_sat`

## Requirements
- R1: Any NaN (exponent field bits 62..52 all ones, fraction bits 51..0 nonzero), whatever its sign, gives the most negative integer (0x80000000 for 32 bits) and raises `out_inv_cvt`.
- R2: A NaN with fraction bit 51 clear is signalling and also raises `out_inv_snan`; a NaN with bit 51 set does not.
- R3: A non-NaN input strictly above 2^(W-1)-1 (including +infinity) gives 2^(W-1)-1 (0x7FFFFFFF for 32 bits) and raises `out_inv_cvt`, whatever the rounding mode.
- R4: A negative input is out of range only after rounding. When the rounded magnitude exceeds 2^(W-1) (including -infinity) the result is the most negative integer and `out_inv_cvt` is raised. A value that rounds to exactly -2^(W-1) is accepted.
- R5: On an invalid conversion, `out_fr` and `out_fi` are both 0.
- R6: `out_we` is high with every result except an invalid one while `in_inv_en` was high with the operand; then it is low.
- R7: `in_rmode` encodings: 00 round to nearest with ties to even, 01 toward zero, 10 toward +infinity, 11 toward -infinity.
- R8: `in_trunc` high forces round toward zero regardless of `in_rmode`.
- R9: For an in-range result, `out_fi` is 1 exactly when the result differs from the input. `out_fr` is 1 exactly when the result's magnitude is larger than the input's.
- R10: `out_valid` is high exactly one cycle after each cycle with `in_valid` high. `out_we`, `out_inv_cvt` and `out_inv_snan` are low whenever `out_valid` is low.
- R11: Zeros of either sign and subnormal inputs convert like any small value: ±0 gives 0 with no status, a subnormal rounds to 0, 1 or -1 by the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_op | input | 64 | Double-precision operand bits |
| in_rmode | input | 2 | Rounding mode (R7 encoding) |
| in_trunc | input | 1 | Force round toward zero |
| in_inv_en | input | 1 | Invalid-operation trap enable; suppresses writeback of invalid results |
| out_valid | output | 1 | Result present |
| out_int | output | INT_W | Converted or clamped integer |
| out_we | output | 1 | Destination write-enable |
| out_inv_cvt | output | 1 | Invalid-conversion exception pulse |
| out_inv_snan | output | 1 | Signalling-NaN exception pulse |
| out_fr | output | 1 | Result rounded up in magnitude |
| out_fi | output | 1 | Result inexact |

## Verification
The bound checker watches, on every cycle, the relations that hold for any operand. These are: the one-cycle valid timing and the gating of the pulses, status cleared on invalid results, and a clamped value whenever an exception is raised. It also checks that a signalling NaN always comes with an invalid conversion, and that the write is withheld under the trap enable. Which limit is chosen, the exact rounding of ties and fractions in each mode, and the asymmetric range edges can only be shown by the bench's scenarios. Those scenarios cover values just past 0x7FFFFFFF and just below -2^31, negative zero and subnormals. Their expected results come from a real-number model.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
   localparam int EXP_W = 11;
   localparam int MAN_W = 52;
   localparam int BIAS  = 1023;

   typedef enum logic [1:0] {
      RND_NEAR = 2'b00,
      RND_ZERO = 2'b01,
      RND_UP   = 2'b10,
      RND_DOWN = 2'b11
   } rnd_mode_e;

   typedef struct packed {
      logic is_nan;
      logic is_snan;
      logic sign;
      logic huge;
   } fcvt_cls_t;
endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
   import fcvt_pkg::*;
#(
   parameter int INT_W = 32
) (
   input  logic [63:0]      op,
   output fcvt_cls_t        cls,
   output logic [INT_W-1:0] mag_int,
   output logic             grd,
   output logic             stk
);
   localparam int FXW = INT_W + MAN_W + 1;
   localparam int SHW = $clog2(INT_W + 1);

   logic [EXP_W-1:0]        expo;
   logic [MAN_W-1:0]        man;
   logic signed [EXP_W+1:0] unb;
   logic                    tiny;
   logic [SHW-1:0]          sh;
   logic [FXW-1:0]          sig_ext;
   logic [FXW-1:0]          fixed;

   assign expo = op[62:52];
   assign man  = op[51:0];
   assign unb  = $signed({2'b00, expo}) - $signed((EXP_W+2)'(BIAS));
   assign tiny = unb < -13'sd1;

   assign cls.sign    = op[63];
   assign cls.is_nan  = (&expo) & (|man);
   assign cls.is_snan = cls.is_nan & ~man[MAN_W-1];
   assign cls.huge    = unb >= $signed((EXP_W+2)'(INT_W));

   // fixed point: value scaled by 2^(MAN_W+1); shift lands the point
   assign sh      = SHW'(unb + 13'sd1);
   assign sig_ext = {{INT_W{1'b0}}, 1'b1, man};
   assign fixed   = sig_ext << sh;

   always_comb begin
      if (tiny) begin
         mag_int = '0;
         grd     = 1'b0;
         stk     = |op[62:0];
      end else begin
         mag_int = fixed[FXW-1 -: INT_W];
         grd     = fixed[MAN_W];
         stk     = |fixed[MAN_W-1:0];
      end
   end
endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
   import fcvt_pkg::*;
#(
   parameter int INT_W = 32
) (
   input  rnd_mode_e        mode,
   input  logic             sign,
   input  logic [INT_W-1:0] mag_in,
   input  logic             grd,
   input  logic             stk,
   output logic             inc,
   output logic [INT_W:0]   mag_out
);
   always_comb begin
      unique case (mode)
         RND_NEAR: inc = grd & (stk | mag_in[0]);
         RND_ZERO: inc = 1'b0;
         RND_UP:   inc = ~sign & (grd | stk);
         default:  inc = sign & (grd | stk);
      endcase
   end

   assign mag_out = {1'b0, mag_in} + {{INT_W{1'b0}}, inc};
endmodule

// File: rtl/fcvt_sat.sv
module fcvt_sat #(
   parameter int INT_W = 32
) (
   input  logic             is_nan,
   input  logic             huge,
   input  logic             sign,
   input  logic [INT_W-1:0] mag_int,
   input  logic             grd,
   input  logic             stk,
   input  logic             inc,
   input  logic [INT_W:0]   mag_rnd,
   output logic [INT_W-1:0] res,
   output logic             invalid,
   output logic             fr,
   output logic             fi
);
   localparam logic [INT_W:0]   POS_LIM = {2'b00, {(INT_W-1){1'b1}}};
   localparam logic [INT_W:0]   NEG_LIM = {2'b01, {(INT_W-1){1'b0}}};
   localparam logic [INT_W-1:0] MAX_V   = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] MIN_V   = {1'b1, {(INT_W-1){1'b0}}};

   logic pos_over, neg_over, inexact;

   assign inexact  = grd | stk;
   // positive side judged on the unrounded value, negative side after rounding
   assign pos_over = ~sign & (({1'b0, mag_int} > POS_LIM) |
                              (({1'b0, mag_int} == POS_LIM) & inexact));
   assign neg_over = sign & (mag_rnd > NEG_LIM);
   assign invalid  = is_nan | huge | pos_over | neg_over;

   always_comb begin
      if (is_nan || (invalid && sign))
         res = MIN_V;
      else if (invalid)
         res = MAX_V;
      else if (sign)
         res = -mag_rnd[INT_W-1:0];
      else
         res = mag_rnd[INT_W-1:0];
   end

   assign fr = ~invalid & inc;
   assign fi = ~invalid & inexact;
endmodule

// File: rtl/dbl2int_sat.sv
module dbl2int_sat
   import fcvt_pkg::*;
#(
   parameter int INT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [63:0]      in_op,
   input  logic [1:0]       in_rmode,
   input  logic             in_trunc,
   input  logic             in_inv_en,
   output logic             out_valid,
   output logic [INT_W-1:0] out_int,
   output logic             out_we,
   output logic             out_inv_cvt,
   output logic             out_inv_snan,
   output logic             out_fr,
   output logic             out_fi
);
   generate
      if (INT_W != 32 && INT_W != 64) begin : g_bad_width
         $error("dbl2int_sat: INT_W must be 32 or 64");
      end
   endgenerate

   fcvt_cls_t        cls;
   logic [INT_W-1:0] mag_int, res;
   logic [INT_W:0]   mag_rnd;
   logic             grd, stk, inc, invalid, fr, fi;
   rnd_mode_e        mode;

   assign mode = in_trunc ? RND_ZERO : rnd_mode_e'(in_rmode);

   fcvt_unpack #(.INT_W(INT_W)) u_unpack (
      .op(in_op), .cls(cls), .mag_int(mag_int), .grd(grd), .stk(stk)
   );

   fcvt_round #(.INT_W(INT_W)) u_round (
      .mode(mode), .sign(cls.sign), .mag_in(mag_int), .grd(grd), .stk(stk),
      .inc(inc), .mag_out(mag_rnd)
   );

   fcvt_sat #(.INT_W(INT_W)) u_sat (
      .is_nan(cls.is_nan), .huge(cls.huge), .sign(cls.sign),
      .mag_int(mag_int), .grd(grd), .stk(stk), .inc(inc), .mag_rnd(mag_rnd),
      .res(res), .invalid(invalid), .fr(fr), .fi(fi)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_we       <= 1'b0;
         out_inv_cvt  <= 1'b0;
         out_inv_snan <= 1'b0;
         out_int      <= '0;
         out_fr       <= 1'b0;
         out_fi       <= 1'b0;
      end else begin
         out_valid    <= in_valid;
         out_we       <= in_valid & ~(invalid & in_inv_en);
         out_inv_cvt  <= in_valid & invalid;
         out_inv_snan <= in_valid & cls.is_snan;
         if (in_valid) begin
            out_int <= res;
            out_fr  <= fr;
            out_fi  <= fi;
         end
      end
   end
endmodule

// File: rtl/dbl2int_sat_chk.sv
module dbl2int_sat_chk #(
   parameter int INT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_inv_en,
   input logic             out_valid,
   input logic [INT_W-1:0] out_int,
   input logic             out_we,
   input logic             out_inv_cvt,
   input logic             out_inv_snan,
   input logic             out_fr,
   input logic             out_fi
);
   localparam logic [INT_W-1:0] MAX_V = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] MIN_V = {1'b1, {(INT_W-1){1'b0}}};

   assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_pulses_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !(out_we || out_inv_cvt || out_inv_snan));
   assert_status_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_inv_cvt |-> (!out_fr && !out_fi));
   assert_snan_is_invalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_inv_snan |-> (out_inv_cvt && out_int == MIN_V));
   // R3 and R4: a raised exception always carries one of the two limits
   assert_clamped_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_inv_cvt |-> (out_int == MIN_V || out_int == MAX_V));
   assert_we_withheld_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_inv_cvt && $past(in_inv_en)) |-> !out_we);
   assert_we_given_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_inv_cvt) |-> out_we);
   assert_fr_needs_fi_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_fr |-> out_fi);
endmodule

bind dbl2int_sat dbl2int_sat_chk #(.INT_W(INT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_inv_en(in_inv_en),
   .out_valid(out_valid), .out_int(out_int), .out_we(out_we),
   .out_inv_cvt(out_inv_cvt), .out_inv_snan(out_inv_snan),
   .out_fr(out_fr), .out_fi(out_fi)
);

// File: tb/dbl2int_sat_bench.sv
module dbl2int_sat_bench;
   localparam int W = 32;
   localparam logic [W-1:0] MAX_V = 32'h7FFFFFFF;
   localparam logic [W-1:0] MIN_V = 32'h80000000;

   typedef struct packed {
      logic [W-1:0] res;
      logic cvi, snan, we, fr, fi;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [63:0]  in_op = '0;
   logic [1:0]   in_rmode = 2'b00;
   logic         in_trunc = 1'b0;
   logic         in_inv_en = 1'b0;
   logic         out_valid, out_we, out_inv_cvt, out_inv_snan, out_fr, out_fi;
   logic [W-1:0] out_int;

   int    n_chk = 0;
   int    n_bad = 0;
   exp_t  exp_q[$];
   string tag_q[$];
   exp_t  mon_e;
   string mon_t;

   always #5 clk = ~clk;

   dbl2int_sat #(.INT_W(W)) u_dbl2int_sat (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_rmode(in_rmode), .in_trunc(in_trunc), .in_inv_en(in_inv_en),
      .out_valid(out_valid), .out_int(out_int), .out_we(out_we),
      .out_inv_cvt(out_inv_cvt), .out_inv_snan(out_inv_snan),
      .out_fr(out_fr), .out_fi(out_fi)
   );

   // reference model built on real arithmetic
   task automatic send(input logic [63:0] op, input logic [1:0] rm,
                       input logic tr, input logic ve, input string tag);
      exp_t e;
      real r, fl, ce, q, d, aq, ar;
      int m;
      e = '0;
      if (op[62:52] == 11'h7FF && op[51:0] != 52'd0) begin
         e.res = MIN_V; e.cvi = 1'b1; e.snan = ~op[51];
      end else begin
         r = $bitstoreal(op);
         if (r > 2147483647.0) begin
            e.res = MAX_V; e.cvi = 1'b1;
         end else if (r < -3.0e9) begin
            e.res = MIN_V; e.cvi = 1'b1;
         end else begin
            fl = $floor(r); ce = $ceil(r);
            m = tr ? 1 : int'(rm);
            case (m)
               0: begin
                  d = r - fl;
                  if (d > 0.5) q = ce;
                  else if (d < 0.5) q = fl;
                  else q = ((longint'(fl) % 2) == 0) ? fl : ce;
               end
               1: q = (r < 0.0) ? ce : fl;
               2: q = ce;
               default: q = fl;
            endcase
            if (q < -2147483648.0) begin
               e.res = MIN_V; e.cvi = 1'b1;
            end else begin
               e.res = W'(longint'(q));
               aq = (q < 0.0) ? -q : q;
               ar = (r < 0.0) ? -r : r;
               e.fi = (q != r);
               e.fr = (aq > ar);
            end
         end
      end
      e.we = !(e.cvi && ve);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_rmode = rm; in_trunc = tr; in_inv_en = ve;
   endtask

   function automatic logic [63:0] dv(input real v);
      return $realtobits(v);
   endfunction

   // monitor: pops the scoreboard as results appear
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R10: unexpected out_valid, got res=%h exp none", out_int);
         end else begin
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            if ({out_int, out_inv_cvt, out_inv_snan, out_we, out_fr, out_fi} !== mon_e) begin
               n_bad++;
               $display("FAIL %s: got res=%h cvi=%b snan=%b we=%b fr=%b fi=%b exp res=%h cvi=%b snan=%b we=%b fr=%b fi=%b",
                        mon_t, out_int, out_inv_cvt, out_inv_snan, out_we, out_fr, out_fi,
                        mon_e.res, mon_e.cvi, mon_e.snan, mon_e.we, mon_e.fr, mon_e.fi);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0 || out_we !== 1'b0 || out_inv_cvt !== 1'b0) begin
         n_bad++;
         $display("FAIL R10: reset got valid=%b we=%b cvi=%b exp 0 0 0", out_valid, out_we, out_inv_cvt);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R7 modes, R9 status
      send(dv(3.0),  2'b00, 1'b0, 1'b0, "R9");
      send(dv(2.5),  2'b00, 1'b0, 1'b0, "R7");
      send(dv(3.5),  2'b00, 1'b0, 1'b0, "R7");
      send(dv(-2.5), 2'b00, 1'b0, 1'b0, "R7");
      send(dv(2.5),  2'b10, 1'b0, 1'b0, "R7");
      send(dv(2.5),  2'b11, 1'b0, 1'b0, "R7");
      send(dv(-2.5), 2'b11, 1'b0, 1'b0, "R7");
      send(dv(-2.7), 2'b01, 1'b0, 1'b0, "R7");
      send(dv(0.3),  2'b00, 1'b0, 1'b0, "R9");
      send(dv(7.75), 2'b00, 1'b0, 1'b0, "R9");
      // R8 truncate overrides
      send(dv(2.7),  2'b10, 1'b1, 1'b0, "R8");
      send(dv(-2.7), 2'b11, 1'b1, 1'b0, "R8");
      // R1, R2 NaNs
      send(64'h7FF8000000000000, 2'b00, 1'b0, 1'b0, "R1");
      send(64'hFFF8000000000123, 2'b10, 1'b0, 1'b0, "R1");
      send(64'h7FF0000000000001, 2'b00, 1'b0, 1'b0, "R2");
      send(64'hFFF4000000000000, 2'b00, 1'b0, 1'b0, "R2");
      // R3 positive edge
      send(dv(2147483647.0), 2'b00, 1'b0, 1'b0, "R3");
      send(dv(2147483646.7), 2'b10, 1'b0, 1'b0, "R3");
      send(dv(2147483647.5), 2'b01, 1'b0, 1'b0, "R3");
      send(dv(2147483648.0), 2'b00, 1'b0, 1'b0, "R3");
      send(64'h7FF0000000000000, 2'b00, 1'b0, 1'b0, "R3");
      send(dv(1.0e20), 2'b11, 1'b0, 1'b0, "R3");
      // R4 negative edge, judged after rounding
      send(dv(-2147483648.0), 2'b00, 1'b0, 1'b0, "R4");
      send(dv(-2147483648.4), 2'b00, 1'b0, 1'b0, "R4");
      send(dv(-2147483648.4), 2'b11, 1'b0, 1'b0, "R4");
      send(dv(-2147483649.0), 2'b01, 1'b0, 1'b0, "R4");
      send(64'hFFF0000000000000, 2'b00, 1'b0, 1'b0, "R4");
      // R5 and R6 with trap enable
      send(dv(5.5e9), 2'b10, 1'b0, 1'b1, "R5");
      send(64'h7FF0000000000002, 2'b00, 1'b0, 1'b1, "R6");
      send(dv(-9.25), 2'b00, 1'b0, 1'b1, "R6");
      send(dv(-4.0e9), 2'b00, 1'b0, 1'b1, "R6");
      // R11 zeros and subnormals
      send(64'h8000000000000000, 2'b00, 1'b0, 1'b0, "R11");
      send(64'h0000000000000000, 2'b11, 1'b0, 1'b0, "R11");
      send(64'h0000000000000001, 2'b10, 1'b0, 1'b0, "R11");
      send(64'h8000000000000001, 2'b11, 1'b0, 1'b0, "R11");
      send(64'h000FFFFFFFFFFFFF, 2'b00, 1'b0, 1'b0, "R11");

      @(negedge clk);
      in_valid = 1'b0;
      // idle gap then a lone operand: R10 spacing
      repeat (3) @(negedge clk);
      send(dv(42.0), 2'b00, 1'b0, 1'b0, "R10");
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);

      n_chk++;
      if (exp_q.size() != 0 || out_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R10: got pending=%0d valid=%b exp pending=0 valid=0", exp_q.size(), out_valid);
      end
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule